// File: doc/BRIEF.md
# Display Refresh Sequencer

This block is the host-side controller that walks a two-plane (black/white and red) electrophoretic display controller through one complete picture refresh. After a start pulse it waits for the panel supply to settle and pulses the panel's active-low reset line. It then polls the controller's busy line and issues a soft reset. Next it streams a full black/white plane and a full red plane, each opened by its own command byte. It triggers the update and waits out the long busy period. It finishes by sending the deep-sleep command with its argument.

Bytes leave through a simple valid/ready transmit port that feeds an external serial shifter, with a flag that marks each byte as command (0) or data (1). Pixel bytes come from an external frame source through a valid/ready pop port. The sequencer forwards them without buffering and tells the source which plane is being read. All delays are worked out from a clock-frequency parameter. Every busy wait is guarded by a timeout that parks the sequence in an error state.

Top module: `epd_refresh_seq`

## Requirements
- R1: A start pulse accepted while idle or in the error state holds `panel_rst_n` high for exactly PWRUP_MS x CLK_HZ / 1000 clock cycles before it drives the reset line low.
- R2: `panel_rst_n` is then held low for exactly RST_LOW_US x CLK_HZ / 10^6 cycles and released. When busy is low, the first command is presented exactly RST_WAIT_US x CLK_HZ / 10^6 + 1 cycles after release.
- R3: Accepted bytes follow this order, with tx_dc = 0 for commands and 1 for data:
  - command 12h, then a wait for busy low;
  - command 24h and PLANE_BYTES data bytes;
  - command 26h and PLANE_BYTES data bytes;
  - command 20h, then a wait for busy low;
  - command 10h and data 01h.
- R4: PLANE_BYTES equals (WIDTH_PX/8) x HEIGHT_PX. Plane bytes are the frame-source bytes, unchanged and in pop order. `pix_plane` is 0 for the black/white plane and 1 for the red plane.
- R5: `pix_ready` is high only during a plane upload, where it equals `tx_ready`. A pixel byte is consumed only when `pix_valid` and `tx_ready` are both high.
- R6: No command byte is presented while `busy` is high, and nothing is presented while `panel_rst_n` is low.
- R7: A transfer happens only on a cycle with `tx_valid` and `tx_ready` high. Stalls on either handshake lose or repeat no byte.
- R8: Each busy wait tolerates up to BUSY_TIMEOUT_US x CLK_HZ / 10^6 - 1 consecutive busy-high cycles. One more cycle raises `err`, which stays high and stops all transfers until the next start.
- R9: `done` is a single-cycle pulse on the cycle after the deep-sleep data byte 01h is accepted. The sequencer is then idle.
- R10: `start` is ignored while a sequence is running. A start from the error state clears `err` and reruns the whole sequence, including the hardware reset.
- R11: While reset is high and after it is released, `panel_rst_n` is high and `tx_valid`, `pix_ready`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a refresh sequence |
| busy | input | 1 | Display controller busy indication |
| tx_ready | input | 1 | Transmitter can take a byte this cycle |
| pix_valid | input | 1 | Frame source has a byte available |
| pix_data | input | 8 | Frame source byte |
| panel_rst_n | output | 1 | Active-low reset to the display controller |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_dc | output | 1 | 0 = command byte, 1 = data byte |
| tx_byte | output | 8 | Byte offered to the transmitter |
| pix_ready | output | 1 | Pops a frame-source byte when high with pix_valid |
| pix_plane | output | 1 | Plane being read: 0 black/white, 1 red |
| done | output | 1 | One-cycle pulse when the sequence has completed |
| err | output | 1 | A busy wait timed out; sequence halted |

## Verification
The bench measures each delay phase to the exact cycle. A timer off by one would lengthen or shorten the reset pulse or the settle gaps and be caught there. Busy is held high after the soft reset for exactly one cycle less than the timeout and then for exactly the timeout. A watchdog comparing at the wrong count either faults a legal wait or lets a hung controller through. Random-looking stalls on both handshakes, busy noise during uploads, and stray start pulses are mixed into full runs. Any lost, duplicated or reordered byte, any command issued under busy, or a restart in mid-sequence shows up as a stream mismatch. A run that restarts from the error state shows whether the fault is cleared and the reset pulse repeated.

// File: rtl/epd_seq_pkg.sv
package epd_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWRUP,
        ST_RST_LOW,
        ST_RST_WAIT,
        ST_BUSY_INIT,
        ST_CMD_SWRST,
        ST_BUSY_SWRST,
        ST_CMD_BW,
        ST_DAT_BW,
        ST_CMD_RED,
        ST_DAT_RED,
        ST_CMD_UPD,
        ST_BUSY_UPD,
        ST_CMD_SLEEP,
        ST_DAT_SLEEP,
        ST_FAULT
    } seq_state_e;

    typedef struct packed {
        logic       vld;
        logic       dc;
        logic [7:0] val;
    } tx_word_t;

    localparam logic [7:0] OP_SOFT_RESET = 8'h12;
    localparam logic [7:0] OP_LOAD_BW    = 8'h24;
    localparam logic [7:0] OP_LOAD_RED   = 8'h26;
    localparam logic [7:0] OP_REFRESH    = 8'h20;
    localparam logic [7:0] OP_SLEEP      = 8'h10;
    localparam logic [7:0] ARG_SLEEP     = 8'h01;

    // Converts a duration in microseconds to clock cycles, never less than one.
    function automatic longint unsigned us_to_cycles(longint unsigned hz, longint unsigned us);
        longint unsigned c;
        c = (hz * us) / 64'd1000000;
        return (c == 0) ? 64'd1 : c;
    endfunction

    function automatic logic is_busy_wait(seq_state_e s);
        return (s == ST_BUSY_INIT) || (s == ST_BUSY_SWRST) || (s == ST_BUSY_UPD);
    endfunction

    function automatic logic is_plane(seq_state_e s);
        return (s == ST_DAT_BW) || (s == ST_DAT_RED);
    endfunction

endpackage

// File: rtl/seq_delay_timer.sv
module seq_delay_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/seq_busy_watchdog.sv
module seq_busy_watchdog #(
    parameter int           W        = 8,
    parameter logic [W-1:0] TERMINAL = '1
) (
    input  logic clk,
    input  logic rst,
    input  logic watch,
    input  logic busy,
    output logic timeout
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !watch) begin
            cnt_q <= '0;
        end else if (busy && cnt_q != TERMINAL) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign timeout = watch && busy && (cnt_q == TERMINAL);
endmodule

// File: rtl/seq_plane_counter.sv
module seq_plane_counter #(
    parameter int           W    = 8,
    parameter logic [W-1:0] LAST = '1
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == LAST);
endmodule

// File: rtl/epd_refresh_seq.sv
module epd_refresh_seq
    import epd_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ          = 200_000_000,
    parameter int unsigned PWRUP_MS        = 10,
    parameter int unsigned RST_LOW_US      = 200,
    parameter int unsigned RST_WAIT_US     = 200,
    parameter int unsigned BUSY_TIMEOUT_US = 30_000_000,
    parameter int unsigned WIDTH_PX        = 152,
    parameter int unsigned HEIGHT_PX       = 296
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       busy,
    input  logic       tx_ready,
    input  logic       pix_valid,
    input  logic [7:0] pix_data,
    output logic       panel_rst_n,
    output logic       tx_valid,
    output logic       tx_dc,
    output logic [7:0] tx_byte,
    output logic       pix_ready,
    output logic       pix_plane,
    output logic       done,
    output logic       err
);
    localparam longint unsigned PWR_CYC  = us_to_cycles(CLK_HZ, longint'(PWRUP_MS) * 1000);
    localparam longint unsigned LOW_CYC  = us_to_cycles(CLK_HZ, RST_LOW_US);
    localparam longint unsigned WAIT_CYC = us_to_cycles(CLK_HZ, RST_WAIT_US);
    localparam longint unsigned TO_CYC   = us_to_cycles(CLK_HZ, BUSY_TIMEOUT_US);
    localparam longint unsigned TMR_MAX  =
        (PWR_CYC > LOW_CYC) ? ((PWR_CYC > WAIT_CYC) ? PWR_CYC : WAIT_CYC)
                            : ((LOW_CYC > WAIT_CYC) ? LOW_CYC : WAIT_CYC);
    localparam int TMR_W = $clog2(TMR_MAX + 1);
    localparam int WD_W  = $clog2(TO_CYC + 1);
    localparam longint unsigned PLANE_BYTES = longint'(WIDTH_PX / 8) * HEIGHT_PX;
    localparam int PB_W = $clog2(PLANE_BYTES + 1);

    localparam logic [TMR_W-1:0] LD_PWR  = TMR_W'(PWR_CYC - 1);
    localparam logic [TMR_W-1:0] LD_LOW  = TMR_W'(LOW_CYC - 1);
    localparam logic [TMR_W-1:0] LD_WAIT = TMR_W'(WAIT_CYC - 1);
    localparam logic [WD_W-1:0]  WD_TERM = WD_W'(TO_CYC - 1);
    localparam logic [PB_W-1:0]  PB_LAST = PB_W'(PLANE_BYTES - 1);

    seq_state_e       state_q, state_d;
    tx_word_t         word;
    logic             done_q, done_d;
    logic             tmr_load, tmr_expired;
    logic [TMR_W-1:0] tmr_val;
    logic             wd_timeout;
    logic             plane_last, plane_step;

    seq_delay_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    seq_busy_watchdog #(.W(WD_W), .TERMINAL(WD_TERM)) u_watchdog (
        .clk     (clk),
        .rst     (rst),
        .watch   (is_busy_wait(state_q)),
        .busy    (busy),
        .timeout (wd_timeout)
    );

    assign plane_step = is_plane(state_q) && pix_valid && tx_ready;

    seq_plane_counter #(.W(PB_W), .LAST(PB_LAST)) u_plane_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (!is_plane(state_q)),
        .step  (plane_step),
        .last  (plane_last)
    );

    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        word      = '{vld: 1'b0, dc: 1'b0, val: 8'h00};
        pix_ready = 1'b0;
        done_d    = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_FAULT: begin
                if (start) begin
                    state_d  = ST_PWRUP;
                    tmr_load = 1'b1;
                    tmr_val  = LD_PWR;
                end
            end
            ST_PWRUP: begin
                if (tmr_expired) begin
                    state_d  = ST_RST_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = LD_LOW;
                end
            end
            ST_RST_LOW: begin
                if (tmr_expired) begin
                    state_d  = ST_RST_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = LD_WAIT;
                end
            end
            ST_RST_WAIT: begin
                if (tmr_expired) state_d = ST_BUSY_INIT;
            end
            ST_BUSY_INIT, ST_BUSY_SWRST, ST_BUSY_UPD: begin
                if (!busy) begin
                    unique case (state_q)
                        ST_BUSY_INIT:  state_d = ST_CMD_SWRST;
                        ST_BUSY_SWRST: state_d = ST_CMD_BW;
                        default:       state_d = ST_CMD_SLEEP;
                    endcase
                end else if (wd_timeout) begin
                    state_d = ST_FAULT;
                end
            end
            ST_CMD_SWRST, ST_CMD_BW, ST_CMD_RED, ST_CMD_UPD, ST_CMD_SLEEP: begin
                word.vld = !busy;
                unique case (state_q)
                    ST_CMD_SWRST: word.val = OP_SOFT_RESET;
                    ST_CMD_BW:    word.val = OP_LOAD_BW;
                    ST_CMD_RED:   word.val = OP_LOAD_RED;
                    ST_CMD_UPD:   word.val = OP_REFRESH;
                    default:      word.val = OP_SLEEP;
                endcase
                if (!busy && tx_ready) begin
                    unique case (state_q)
                        ST_CMD_SWRST: state_d = ST_BUSY_SWRST;
                        ST_CMD_BW:    state_d = ST_DAT_BW;
                        ST_CMD_RED:   state_d = ST_DAT_RED;
                        ST_CMD_UPD:   state_d = ST_BUSY_UPD;
                        default:      state_d = ST_DAT_SLEEP;
                    endcase
                end
            end
            ST_DAT_BW, ST_DAT_RED: begin
                word      = '{vld: pix_valid, dc: 1'b1, val: pix_data};
                pix_ready = tx_ready;
                if (plane_step && plane_last) begin
                    state_d = (state_q == ST_DAT_BW) ? ST_CMD_RED : ST_CMD_UPD;
                end
            end
            ST_DAT_SLEEP: begin
                word = '{vld: 1'b1, dc: 1'b1, val: ARG_SLEEP};
                if (tx_ready) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
        end
    end

    assign panel_rst_n = (state_q != ST_RST_LOW);
    assign tx_valid    = word.vld;
    assign tx_dc       = word.dc;
    assign tx_byte     = word.val;
    assign pix_plane   = (state_q == ST_DAT_RED);
    assign done        = done_q;
    assign err         = (state_q == ST_FAULT);
endmodule

// File: rtl/epd_refresh_seq_chk.sv
module epd_refresh_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       tx_ready,
    input logic       pix_valid,
    input logic       panel_rst_n,
    input logic       tx_valid,
    input logic       tx_dc,
    input logic [7:0] tx_byte,
    input logic       pix_ready,
    input logic       done,
    input logic       err
);
    assert_no_cmd_under_busy_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_dc) |-> !busy);

    assert_quiet_in_reset_R6: assert property (@(posedge clk) disable iff (rst)
        !panel_rst_n |-> !tx_valid);

    assert_pop_only_in_plane_R5: assert property (@(posedge clk) disable iff (rst)
        pix_ready |-> (tx_dc && tx_ready && (tx_valid == pix_valid)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_sleep_arg_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(tx_valid && tx_ready && tx_dc && (tx_byte == 8'h01)));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (err && !start) |=> err);

    assert_err_halts_R8: assert property (@(posedge clk) disable iff (rst)
        err |-> (!tx_valid && !pix_ready && !done));
endmodule

bind epd_refresh_seq epd_refresh_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .busy        (busy),
    .tx_ready    (tx_ready),
    .pix_valid   (pix_valid),
    .panel_rst_n (panel_rst_n),
    .tx_valid    (tx_valid),
    .tx_dc       (tx_dc),
    .tx_byte     (tx_byte),
    .pix_ready   (pix_ready),
    .done        (done),
    .err         (err)
);

// File: tb/tb_epd_refresh_seq.sv
`timescale 1ns/100ps
module tb_epd_refresh_seq;
    localparam int CLK_HZ  = 1_000_000;
    localparam int PWR_MS  = 1;
    localparam int LOW_US  = 20;
    localparam int WAIT_US = 30;
    localparam int TO_US   = 50;
    localparam int W_PX    = 16;
    localparam int H_PX    = 3;
    localparam int PWR_N   = CLK_HZ / 1000 * PWR_MS;
    localparam int LOW_N   = LOW_US;
    localparam int WAIT_N  = WAIT_US;
    localparam int TO_N    = TO_US;
    localparam int PB      = (W_PX / 8) * H_PX;
    localparam int EXP_LEN = 2 * PB + 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy = 1'b0;
    logic tx_ready = 1'b0;
    logic pix_valid = 1'b0;
    logic [7:0] pix_data = 8'h00;
    logic panel_rst_n, tx_valid, tx_dc, pix_ready, pix_plane, done, err;
    logic [7:0] tx_byte;

    always #2.5 clk = ~clk;

    epd_refresh_seq #(
        .CLK_HZ(CLK_HZ), .PWRUP_MS(PWR_MS), .RST_LOW_US(LOW_US),
        .RST_WAIT_US(WAIT_US), .BUSY_TIMEOUT_US(TO_US),
        .WIDTH_PX(W_PX), .HEIGHT_PX(H_PX)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .tx_ready(tx_ready),
        .pix_valid(pix_valid), .pix_data(pix_data), .panel_rst_n(panel_rst_n),
        .tx_valid(tx_valid), .tx_dc(tx_dc), .tx_byte(tx_byte), .pix_ready(pix_ready),
        .pix_plane(pix_plane), .done(done), .err(err)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int rdy_mode = 0;
    int pv_mode = 0;
    bit noise = 1'b0;
    bit stuck = 1'b0;
    int busy_hold = 5;
    int busy_cnt = 0;
    int got = 0;
    int idx_bw = 0;
    int idx_red = 0;
    int done_cnt = 0;
    bit done_prev = 1'b0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(bit plane, int idx);
        return (plane ? 8'hA5 : 8'h3C) ^ 8'(idx * 7 + 1);
    endfunction

    function automatic logic [8:0] exp_entry(int i);
        if (i == 0) return {1'b0, 8'h12};
        if (i == 1) return {1'b0, 8'h24};
        if (i < PB + 2) return {1'b1, pat(1'b0, i - 2)};
        if (i == PB + 2) return {1'b0, 8'h26};
        if (i < 2 * PB + 3) return {1'b1, pat(1'b1, i - PB - 3)};
        if (i == 2 * PB + 3) return {1'b0, 8'h20};
        if (i == 2 * PB + 4) return {1'b0, 8'h10};
        return {1'b1, 8'h01};
    endfunction

    // Stimulus generator and stream monitor.
    always begin
        @(negedge clk);
        cyc++;
        tx_ready  = (rdy_mode == 0) ? 1'b1 : (cyc % 3 != 0);
        pix_valid = (pv_mode == 0) ? 1'b1 : (cyc % 4 != 1);
        busy      = stuck || (busy_cnt > 0) || (noise && (cyc % 7 < 2));
        if (busy_cnt > 0) busy_cnt--;
        pix_data  = pat(pix_plane, pix_plane ? idx_red : idx_bw);
        #1;
        if (!rst) begin
            if (tx_valid && !tx_dc && busy)
                chk(1'b0, "R6", "command offered under busy", tx_byte, 0);
            if (!panel_rst_n && tx_valid)
                chk(1'b0, "R6", "byte offered during reset", tx_byte, 0);
            if (pix_ready && (!tx_dc || pix_ready != tx_ready))
                chk(1'b0, "R5", "pop outside plane upload", pix_ready, 0);
            if (tx_valid && tx_ready) begin
                if (got < EXP_LEN) begin
                    chk({tx_dc, tx_byte} == exp_entry(got), "R3", $sformatf("stream byte %0d", got),
                        {tx_dc, tx_byte}, exp_entry(got));
                    if (tx_dc && got >= 2 && got < 2 * PB + 3)
                        chk(pix_plane == (got > PB + 2), "R4", "plane select", pix_plane, got > PB + 2);
                end else begin
                    chk(1'b0, "R7", "extra byte", {tx_dc, tx_byte}, 0);
                end
                got++;
                if (!tx_dc && (tx_byte == 8'h12 || tx_byte == 8'h20)) busy_cnt = busy_hold;
            end
            if (pix_ready && pix_valid) begin
                if (pix_plane) idx_red++;
                else idx_bw++;
            end
            if (done) begin
                done_cnt++;
                chk(got == EXP_LEN && !done_prev, "R9", "done timing", got, EXP_LEN);
            end
            done_prev = done;
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic new_run(int rm, int pm, bit nz, bit st, int hold);
        rdy_mode = rm; pv_mode = pm; noise = nz; stuck = st; busy_hold = hold;
        busy_cnt = 0; got = 0; idx_bw = 0; idx_red = 0; done_cnt = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Sample counts: high before the low pulse, low width, high after release until tx/err.
    task automatic measure(output int pre, output int low, output int post, input bit until_err);
        pre = 0; low = 0; post = 0;
        #1;
        while (panel_rst_n && pre < 5000) begin pre++; @(negedge clk); #1; end
        while (!panel_rst_n && low < 5000) begin low++; @(negedge clk); #1; end
        while ((until_err ? !err : !tx_valid) && post < 5000) begin post++; @(negedge clk); #1; end
    endtask

    task automatic wait_end(bit poke);
        for (int k = 0; k < 8000; k++) begin
            @(negedge clk);
            start = poke && (k % 97 == 50);
            #1;
            if (done_cnt > 0 || err) break;
        end
        start = 1'b0;
    endtask

    initial begin
        int pre, low, post;
        repeat (4) @(negedge clk);
        #1;
        chk(panel_rst_n && !tx_valid && !pix_ready && !done && !err, "R11", "state under reset",
            {panel_rst_n, tx_valid, pix_ready, done, err}, 5'b10000);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(panel_rst_n && !tx_valid && !pix_ready && !done && !err, "R11", "idle after reset",
            {panel_rst_n, tx_valid, pix_ready, done, err}, 5'b10000);

        // Run A: no stalls, exact delay phases.
        new_run(0, 0, 1'b0, 1'b0, 5);
        pulse_start();
        measure(pre, low, post, 1'b0);
        chk(pre == PWR_N, "R1", "power-up wait", pre, PWR_N);
        chk(low == LOW_N, "R2", "reset low width", low, LOW_N);
        chk(post == WAIT_N + 1, "R2", "release to first command", post, WAIT_N + 1);
        wait_end(1'b0);
        chk(got == EXP_LEN && done_cnt == 1 && !err, "R3", "run A completes", got, EXP_LEN);
        repeat (10) @(negedge clk);
        #1;
        chk(done_cnt == 1 && got == EXP_LEN && !tx_valid, "R9", "idle after done", done_cnt, 1);

        // Run B: stalls on both ports, busy noise, stray starts.
        new_run(1, 1, 1'b1, 1'b0, 9);
        pulse_start();
        wait_end(1'b1);
        chk(got == EXP_LEN && done_cnt == 1 && !err, "R7", "stalled run completes", got, EXP_LEN);
        chk(idx_bw == PB && idx_red == PB, "R5", "pixel pops per plane", idx_bw * 100 + idx_red, PB * 101);
        chk(done_cnt == 1, "R10", "stray starts ignored", done_cnt, 1);

        // Run C: busy one cycle short of the timeout.
        new_run(0, 0, 1'b0, 1'b0, TO_N - 1);
        pulse_start();
        wait_end(1'b0);
        chk(!err && got == EXP_LEN, "R8", "busy TO-1 tolerated", err, 0);

        // Run D: busy exactly at the timeout after soft reset.
        new_run(0, 0, 1'b0, 1'b0, TO_N);
        pulse_start();
        wait_end(1'b0);
        chk(err == 1'b1, "R8", "timeout raises err", err, 1);
        repeat (30) @(negedge clk);
        #1;
        chk(err && got == 1 && done_cnt == 0, "R8", "halted after timeout", got, 1);

        // Run E: busy stuck from the start.
        new_run(0, 0, 1'b0, 1'b1, 5);
        pulse_start();
        chk(!err, "R10", "start clears err", err, 0);
        measure(pre, low, post, 1'b1);
        chk(pre == PWR_N && low == LOW_N, "R1", "restart repeats reset", pre, PWR_N);
        chk(post == WAIT_N + TO_N, "R8", "stuck busy timeout cycle", post, WAIT_N + TO_N);
        chk(got == 0, "R6", "nothing sent while stuck", got, 0);

        // Run F: recovery from the error state.
        new_run(1, 0, 1'b0, 1'b0, 3);
        pulse_start();
        #1;
        chk(!err, "R10", "err cleared on restart", err, 0);
        measure(pre, low, post, 1'b0);
        chk(low == LOW_N, "R2", "reset pulse after fault", low, LOW_N);
        wait_end(1'b0);
        chk(got == EXP_LEN && done_cnt == 1 && !err, "R10", "recovered run completes", got, EXP_LEN);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule